// File: doc/BRIEF.md
# Polling Receiver Power Controller

This block duty-cycles a low-power receiver. While polling, it keeps the signal path off for a programmed sleep interval. It then powers the path up for a start-up interval so that the path can settle. Next it asks an external edge-timing checker whether a genuine transmitter is present. If the checker passes the signal, the controller holds the receiver on continuously. If the check fails, the controller goes back to sleep and a new polling round begins.

All interval counting advances on a base-clock tick strobe. The sleep interval is derived from a 5-bit code, an extension multiplier and a fixed 1024-tick unit. The all-ones code parks the receiver off until a different code is written. A polling/on control line lets a host force continuous reception, and an OFF strobe ends reception.

The states are SLEEP, STARTUP, CHECK and RECEIVE. The transitions are:

- SLEEP→STARTUP when the sleep count expires.
- STARTUP→CHECK when the start-up count expires.
- CHECK→RECEIVE when the check passes.
- CHECK→SLEEP when the check fails.
- RECEIVE→SLEEP on an OFF strobe.
- any state→RECEIVE while the polling line is low.
- RECEIVE→SLEEP when the polling line rises.

Top module: `poll_power_ctrl`

## Requirements
- R1: After reset the controller is in SLEEP, with `active`, `path_en`, `chk_start` and `rx_mode` all low.
- R2: Let N be the sleep count, N = code × X × 1024, where X is the extension multiplier. On entry to SLEEP, N is loaded. SLEEP is left on the (N+1)-th `tick` after entry, and cycles without `tick` do not advance the count.
- R3: X is 1 when `sleep_ext` is 0 and 8 when `sleep_ext` is 1.
- R4: A sleep code of 31 (all ones) keeps the controller in SLEEP indefinitely.
- R5: While the controller is parked by code 31, writing any other code reloads the sleep count from the new code on the next clock. The normal countdown follows, so SLEEP is left after N+1 further ticks.
- R6: A sleep code of 0 gives a zero-length sleep: the first tick in SLEEP moves the controller to STARTUP.
- R7: `active` and `path_en` are low in SLEEP and high in the other three states. `chk_start` is high only in CHECK, and `rx_mode` is high only in RECEIVE.
- R8: On entry to STARTUP, `startup_len` (L) is loaded. CHECK is entered on the (L+1)-th tick.
- R9: In CHECK, when `chk_done` is high the controller moves to RECEIVE if `chk_pass` is 1 and to SLEEP if `chk_pass` is 0. This transition does not wait for a tick.
- R10: In RECEIVE, `off_cmd` returns the controller to SLEEP on the next clock. It has no effect while `poll_mode` is low.
- R11: A low level on `poll_mode` forces RECEIVE on the next clock from any state. A rise of `poll_mode` sends the controller to SLEEP with a freshly loaded sleep count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Base-clock tick strobe that advances the interval counters |
| sleep_code | input | 5 | Sleep multiplier code; 31 means park |
| sleep_ext | input | 1 | Extension select: 0 gives ×1, 1 gives ×8 |
| startup_len | input | 8 | Start-up interval in ticks, minus one |
| chk_done | input | 1 | Checker has finished its verdict |
| chk_pass | input | 1 | Checker verdict: 1 means a valid signal |
| poll_mode | input | 1 | 1 = polling cycle, 0 = force continuous reception |
| off_cmd | input | 1 | Strobe that ends reception |
| path_en | output | 1 | Signal-path power enable |
| active | output | 1 | Active indicator (low only in SLEEP) |
| chk_start | output | 1 | Request to the edge checker, held during CHECK |
| rx_mode | output | 1 | Continuous reception flag |

## Verification
The checker watches the one-cycle transitions on every cycle:

- a pass verdict leads to reception (R9);
- a fail verdict or an OFF strobe drops `active` (R9, R10);
- a low polling line forces reception (R11);
- SLEEP only ever leads to SLEEP or STARTUP (R7);
- STARTUP does not advance without a tick (R8).

Only the bench's scenarios can show the long interval lengths. These are the N+1 tick count for several codes with both extension settings (R2, R3, R6), the start-up length (R8), the indefinite park at code 31 and the restart after it is reprogrammed (R4, R5). These properties span thousands of cycles and depend on values loaded at state entry.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
    typedef enum logic [1:0] {
        ST_SLEEP   = 2'd0,
        ST_STARTUP = 2'd1,
        ST_CHECK   = 2'd2,
        ST_RECEIVE = 2'd3
    } ppc_state_e;
endpackage

// File: rtl/ppc_sleep_timer.sv
module ppc_sleep_timer #(
    parameter int CODE_W  = 5,
    parameter int EXT_MUL = 8,
    parameter int UNIT    = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic              in_sleep,
    input  logic [CODE_W-1:0] code,
    input  logic              ext,
    output logic              expire
);
    localparam int MAXCNT = ((1 << CODE_W) - 1) * EXT_MUL * UNIT;
    localparam int CNT_W  = $clog2(MAXCNT + 1);
    localparam logic [CODE_W-1:0] PARK = '1;

    logic [CNT_W-1:0]  cnt_q;
    logic [CODE_W-1:0] lat_q;
    logic [CNT_W-1:0]  reload_val;
    logic              reprog;

    // Length of the sleep interval for the current code and extension setting.
    always_comb begin
        reload_val = CNT_W'(code) * (ext ? CNT_W'(EXT_MUL) : CNT_W'(1)) * CNT_W'(UNIT);
    end

    // A parked controller restarts the countdown as soon as the code leaves the park value.
    assign reprog = in_sleep && (lat_q == PARK) && (code != PARK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lat_q <= PARK;
        end else if (load || reprog) begin
            cnt_q <= reload_val;
            lat_q <= code;
        end else if (in_sleep && tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = in_sleep && tick && (cnt_q == '0) && (lat_q != PARK);
endmodule

// File: rtl/ppc_startup_timer.sv
module ppc_startup_timer #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic             running,
    input  logic [LEN_W-1:0] len,
    output logic             expire
);
    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len;
        end else if (running && tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = running && tick && (cnt_q == '0);
endmodule

// File: rtl/poll_power_ctrl.sv
module poll_power_ctrl
    import ppc_pkg::*;
#(
    parameter int CODE_W  = 5,
    parameter int EXT_MUL = 8,
    parameter int UNIT    = 1024,
    parameter int LEN_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CODE_W-1:0] sleep_code,
    input  logic              sleep_ext,
    input  logic [LEN_W-1:0]  startup_len,
    input  logic              chk_done,
    input  logic              chk_pass,
    input  logic              poll_mode,
    input  logic              off_cmd,
    output logic              path_en,
    output logic              active,
    output logic              chk_start,
    output logic              rx_mode
);
    ppc_state_e state_q, state_d;
    logic       poll_q;
    logic       sleep_exp, start_exp;
    logic       sleep_load, start_load;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        if (!poll_mode) begin
            state_d = ST_RECEIVE;
        end else if (!poll_q) begin
            state_d = ST_SLEEP;
        end else begin
            unique case (state_q)
                ST_SLEEP:   if (sleep_exp) state_d = ST_STARTUP;
                ST_STARTUP: if (start_exp) state_d = ST_CHECK;
                ST_CHECK:   if (chk_done)  state_d = chk_pass ? ST_RECEIVE : ST_SLEEP;
                ST_RECEIVE: if (off_cmd)   state_d = ST_SLEEP;
                default:    state_d = ST_SLEEP;
            endcase
        end
    end

    assign sleep_load = (state_d == ST_SLEEP)   && (state_q != ST_SLEEP);
    assign start_load = (state_d == ST_STARTUP) && (state_q != ST_STARTUP);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SLEEP;
            poll_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            poll_q  <= poll_mode;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        path_en   = 1'b1;
        active    = 1'b1;
        chk_start = 1'b0;
        rx_mode   = 1'b0;
        unique case (state_q)
            ST_SLEEP: begin
                path_en = 1'b0;
                active  = 1'b0;
            end
            ST_STARTUP: ;
            ST_CHECK:   chk_start = 1'b1;
            ST_RECEIVE: rx_mode   = 1'b1;
            default: begin
                path_en = 1'b0;
                active  = 1'b0;
            end
        endcase
    end

    ppc_sleep_timer #(
        .CODE_W  (CODE_W),
        .EXT_MUL (EXT_MUL),
        .UNIT    (UNIT)
    ) i_sleep (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (sleep_load),
        .in_sleep (state_q == ST_SLEEP),
        .code     (sleep_code),
        .ext      (sleep_ext),
        .expire   (sleep_exp)
    );

    ppc_startup_timer #(
        .LEN_W (LEN_W)
    ) i_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .load    (start_load),
        .running (state_q == ST_STARTUP),
        .len     (startup_len),
        .expire  (start_exp)
    );
endmodule

// File: rtl/poll_power_ctrl_chk.sv
module poll_power_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic chk_done,
    input logic chk_pass,
    input logic poll_mode,
    input logic off_cmd,
    input logic active,
    input logic chk_start,
    input logic rx_mode
);
    // R9: a passing verdict leads to reception.
    a_r9_pass_to_rx: assert property (@(posedge clk) disable iff (!rst_n)
        chk_start && chk_done && chk_pass && poll_mode |=> rx_mode);

    // R9: a failing verdict leads back to sleep.
    a_r9_fail_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        chk_start && chk_done && !chk_pass && poll_mode |=> !active);

    // R10: OFF during reception with polling enabled returns to sleep.
    a_r10_off_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
        rx_mode && off_cmd && poll_mode |=> !active);

    // R11: a low polling line forces reception.
    a_r11_force_rx: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_mode |=> rx_mode);

    // R7: sleep leads only to sleep or start-up.
    a_r7_sleep_successor: assert property (@(posedge clk) disable iff (!rst_n)
        !active && poll_mode |=> !rx_mode && !chk_start);

    // R8: start-up does not advance without a tick.
    a_r8_startup_waits_tick: assert property (@(posedge clk) disable iff (!rst_n)
        active && !chk_start && !rx_mode && poll_mode && !tick |=> !chk_start);
endmodule

bind poll_power_ctrl poll_power_ctrl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .chk_done  (chk_done),
    .chk_pass  (chk_pass),
    .poll_mode (poll_mode),
    .off_cmd   (off_cmd),
    .active    (active),
    .chk_start (chk_start),
    .rx_mode   (rx_mode)
);

// File: tb/test_poll_power_ctrl.sv
module test_poll_power_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic [4:0] sleep_code = 5'd0;
    logic       sleep_ext = 1'b0;
    logic [7:0] startup_len = 8'd0;
    logic       chk_done = 1'b0;
    logic       chk_pass = 1'b0;
    logic       poll_mode = 1'b1;
    logic       off_cmd = 1'b0;
    logic       path_en, active, chk_start, rx_mode;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    poll_power_ctrl i_poll_power_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .sleep_code  (sleep_code),
        .sleep_ext   (sleep_ext),
        .startup_len (startup_len),
        .chk_done    (chk_done),
        .chk_pass    (chk_pass),
        .poll_mode   (poll_mode),
        .off_cmd     (off_cmd),
        .path_en     (path_en),
        .active      (active),
        .chk_start   (chk_start),
        .rx_mode     (rx_mode)
    );

    typedef struct packed {
        logic [4:0] code;
        logic       ext;
        logic [7:0] len;
        logic       pass;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{code: 5'd0, ext: 1'b0, len: 8'd0, pass: 1'b1},
        '{code: 5'd1, ext: 1'b0, len: 8'd3, pass: 1'b0},
        '{code: 5'd2, ext: 1'b1, len: 8'd5, pass: 1'b1},
        '{code: 5'd3, ext: 1'b0, len: 8'd0, pass: 1'b1},
        '{code: 5'd0, ext: 1'b1, len: 8'd9, pass: 1'b0}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Enter SLEEP with a fresh count by pulsing the polling line low then high.
    task automatic enter_sleep_via_poll();
        poll_mode = 1'b0;
        @(negedge clk);
        poll_mode = 1'b1;
        @(negedge clk);
    endtask

    task automatic count_sleep(output int n);
        n = 0;
        while (!active && n < 40000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic count_startup(output int n);
        n = 0;
        while (active && !chk_start && !rx_mode && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        #(20 * 190000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int n;
        int hi_cnt;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 active at reset", int'(active), 0);
        check("R1 path_en at reset", int'(path_en), 0);
        check("R1 outputs at reset", int'({chk_start, rx_mode}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2, R3, R6, R7, R8, R9
        for (int i = 0; i < 5; i++) begin
            sleep_code  = VECS[i].code;
            sleep_ext   = VECS[i].ext;
            startup_len = VECS[i].len;
            enter_sleep_via_poll();
            check("R7 path_en low in sleep", int'(path_en), 0);
            count_sleep(n);
            check("R2 R3 R6 sleep length",
                  n, int'(VECS[i].code) * (VECS[i].ext ? 8 : 1) * 1024 + 1);
            check("R7 path_en high after sleep", int'(path_en), 1);
            count_startup(n);
            check("R8 startup length", n, int'(VECS[i].len) + 1);
            check("R7 chk_start in check", int'(chk_start), 1);
            chk_pass = VECS[i].pass;
            chk_done = 1'b1;
            @(negedge clk);
            chk_done = 1'b0;
            check("R9 verdict rx_mode", int'(rx_mode), int'(VECS[i].pass));
            check("R9 verdict active", int'(active), int'(VECS[i].pass));
        end

        // R10: OFF ends reception
        sleep_code = 5'd2;
        sleep_ext  = 1'b0;
        poll_mode  = 1'b0;
        @(negedge clk);
        poll_mode  = 1'b1;
        chk_done   = 1'b0;
        @(negedge clk);
        // now SLEEP after the rise; get into RECEIVE by forcing it again
        poll_mode = 1'b0;
        @(negedge clk);
        check("R11 forced receive", int'(rx_mode), 1);
        off_cmd = 1'b1;
        @(negedge clk);
        check("R10 off ignored while poll low", int'(rx_mode), 1);
        off_cmd = 1'b0;
        poll_mode = 1'b1;
        @(negedge clk);
        check("R11 rise returns to sleep", int'(active), 0);
        count_sleep(n);
        check("R11 fresh sleep count after rise", n, 2 * 1024 + 1);
        // run a pass to reach RECEIVE with polling high
        count_startup(n);
        chk_pass = 1'b1;
        chk_done = 1'b1;
        @(negedge clk);
        chk_done = 1'b0;
        check("R9 pass reaches receive", int'(rx_mode), 1);
        off_cmd = 1'b1;
        @(negedge clk);
        off_cmd = 1'b0;
        check("R10 off returns to sleep", int'(active), 0);

        // R2: no tick, no progress (code 0)
        sleep_code = 5'd0;
        tick = 1'b0;
        enter_sleep_via_poll();
        repeat (20) @(negedge clk);
        check("R2 sleep holds without tick", int'(active), 0);
        tick = 1'b1;
        @(negedge clk);
        check("R6 zero sleep leaves on first tick", int'(active), 1);

        // R4: park at code 31
        sleep_code = 5'd31;
        sleep_ext  = 1'b0;
        enter_sleep_via_poll();
        hi_cnt = 0;
        for (int k = 0; k < 33000; k++) begin
            if (active) hi_cnt++;
            @(negedge clk);
        end
        check("R4 parked sleep never wakes", hi_cnt, 0);

        // R5: reprogram while parked
        sleep_code = 5'd1;
        @(negedge clk);
        count_sleep(n);
        check("R5 restart after reprogram", n, 1024 + 1);
        check("R5 reaches startup", int'(active && !chk_start && !rx_mode), 1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule